// File: doc/BRIEF.md
# Motor Drive Protection Supervisor

This block watches over a motor drive loop. It counts a slow supervisor tick in the system clock domain and from it produces three safety functions: an internal reset held after power-on, a flag that reports loss of the speed reference clock, and a stall detector that latches the PWM drive off when the motor's feedback pulse (FG) stops toggling.

The tick, the reference clock, the FG signal and the start/stop request are asynchronous levels. Each passes through a two-flop synchroniser, and the first three are then reduced to single-cycle rising-edge pulses. Thermal and undervoltage faults arrive as logic levels. They force the drive off only while they are asserted. A stall fault stays latched until the supervisor sits in the stop state for a minimum number of ticks, or until power-on reset is applied again.

Top module: `motor_guard_sup`

## Requirements
- R1: While `rst_n` is low, and after its release until POR_TICKS (default 1) synchronised tick rising edges have been seen, `core_rst` is 1, `drive_off` is 1 and `intermit` is 0.
- R2: While `stop_req` is 1 (1 = stop, 0 = run), `drive_off` is 1.
- R3: In the run state, once CLK_LOSS_TICKS (default 2) tick rising edges occur with no reference rising edge between them, `intermit` becomes 1. After only one such tick it stays 0.
- R4: A rising edge of `ref_in` clears `intermit` and restarts the clock-loss count.
- R5: In the run state, the STALL_TICKS-th (default 31) tick rising edge with no FG rising edge latches the stall fault, and `drive_off` becomes 1. After 30 such ticks the drive stays on.
- R6: Each FG rising edge restarts the stall count.
- R7: The stall latch holds `drive_off` at 1 even after FG and the reference clock resume. A stop that lasts fewer than STOP_TICKS (default 3) ticks leaves the latch set. A stop that lasts STOP_TICKS ticks clears it.
- R8: `therm_flt` or `uv_flt` at 1 forces `drive_off` to 1 while asserted. The drive recovers as soon as the fault drops, with nothing latched.
- R9: The stop state clears `intermit` and both timeout counters.
- R10: Asserting `rst_n` low clears a latched stall fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick_in | input | 1 | Slow supervisor tick, asynchronous |
| ref_in | input | 1 | Speed reference clock, asynchronous |
| fg_in | input | 1 | Motor FG feedback, asynchronous |
| stop_req | input | 1 | 1 = stop, 0 = run, asynchronous |
| therm_flt | input | 1 | Thermal fault level |
| uv_flt | input | 1 | Undervoltage fault level |
| core_rst | output | 1 | Internal reset for the control logic |
| intermit | output | 1 | Reference clock lost; intermittent operation |
| drive_off | output | 1 | Disable for PWM drive |

## Verification
A rising edge on `tick_in`, `ref_in` or `fg_in` reaches a registered output on the third clock edge after the input changes: two synchroniser flops, then the edge pulse that is consumed at the next edge. `stop_req` takes effect two edges after it changes. The fault inputs act on `drive_off` at once. The driver holds every pulse high for four cycles and then leaves at least four quiet cycles before it queues an expected output word. It also never lets a tick coincide with a reference or FG edge. As a result, every comparison falls well after the last result was due and before the next stimulus.

// File: rtl/motor_guard_sup.sv
module motor_guard_sup #(
  parameter int POR_TICKS      = 1,
  parameter int CLK_LOSS_TICKS = 2,
  parameter int STALL_TICKS    = 31,
  parameter int STOP_TICKS     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  input  logic ref_in,
  input  logic fg_in,
  input  logic stop_req,
  input  logic therm_flt,
  input  logic uv_flt,
  output logic core_rst,
  output logic intermit,
  output logic drive_off
);
  localparam int PW = $clog2(POR_TICKS + 1);
  localparam int LW = $clog2(CLK_LOSS_TICKS + 1);
  localparam int SW = $clog2(STALL_TICKS + 1);
  localparam int DW = $clog2(STOP_TICKS + 1);

  logic [3:0] sy1, sy2;
  logic [2:0] prv;
  logic [PW-1:0] por_cnt;
  logic [LW-1:0] loss_cnt;
  logic [SW-1:0] stall_cnt;
  logic [DW-1:0] stop_cnt;
  logic core_rst_q, intermit_q, stall_lat;

  wire tick_p = sy2[0] & ~prv[0];
  wire ref_p  = sy2[1] & ~prv[1];
  wire fg_p   = sy2[2] & ~prv[2];
  wire stop_s = sy2[3];
  wire hold   = core_rst_q | stop_s;

  assign core_rst  = core_rst_q;
  assign intermit  = intermit_q;
  assign drive_off = core_rst_q | stop_s | stall_lat | therm_flt | uv_flt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '0; sy2 <= '0; prv <= '0;
      por_cnt <= '0; loss_cnt <= '0; stall_cnt <= '0; stop_cnt <= '0;
      core_rst_q <= 1'b1; intermit_q <= 1'b0; stall_lat <= 1'b0;
    end else begin
      sy1 <= {stop_req, fg_in, ref_in, tick_in};
      sy2 <= sy1;
      prv <= sy2[2:0];

      if (core_rst_q && tick_p) begin
        if (por_cnt == PW'(POR_TICKS - 1)) core_rst_q <= 1'b0;
        else por_cnt <= por_cnt + 1'b1;
      end

      if (hold || ref_p) begin
        loss_cnt <= '0;
        intermit_q <= 1'b0;
      end else if (tick_p && !intermit_q) begin
        if (loss_cnt == LW'(CLK_LOSS_TICKS - 1)) intermit_q <= 1'b1;
        else loss_cnt <= loss_cnt + 1'b1;
      end

      if (hold || fg_p) stall_cnt <= '0;
      else if (tick_p && !stall_lat) begin
        if (stall_cnt == SW'(STALL_TICKS - 1)) begin
          stall_lat <= 1'b1;
          stall_cnt <= '0;
        end else stall_cnt <= stall_cnt + 1'b1;
      end

      if (!stop_s) stop_cnt <= '0;
      else if (tick_p && stall_lat) begin
        if (stop_cnt == DW'(STOP_TICKS - 1)) begin
          stall_lat <= 1'b0;
          stop_cnt <= '0;
        end else stop_cnt <= stop_cnt + 1'b1;
      end
    end
  end

  AST_POR_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst_q) |-> $past(tick_p)); // R1
  AST_REF_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ref_p |=> !intermit_q); // R4
  AST_STALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_lat) |-> $past(tick_p) && !$past(stop_s)); // R5
  AST_STALL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    stall_cnt < SW'(STALL_TICKS)); // R6
  AST_STALL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stall_lat && !stop_s |=> stall_lat); // R7
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_s |=> !intermit_q && loss_cnt == '0 && stall_cnt == '0); // R9
endmodule

// File: tb/motor_guard_sup_bench.sv
module motor_guard_sup_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_in = 1'b0, ref_in = 1'b0, fg_in = 1'b0, stop_req = 1'b0;
  logic therm_flt = 1'b0, uv_flt = 1'b0;
  logic core_rst, intermit, drive_off;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  typedef struct { string tag; logic [2:0] exp; } item_t;
  item_t sbq[$];

  always #2.5 clk = ~clk;

  motor_guard_sup u_motor_guard_sup (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .ref_in(ref_in), .fg_in(fg_in),
    .stop_req(stop_req), .therm_flt(therm_flt), .uv_flt(uv_flt),
    .core_rst(core_rst), .intermit(intermit), .drive_off(drive_off));

  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if ({core_rst, intermit, drive_off} !== it.exp) begin
        failures++;
        $display("FAIL %s got {rst,int,off}=%b expected %b", it.tag,
                 {core_rst, intermit, drive_off}, it.exp);
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string tag, input logic [2:0] e);
    item_t it;
    it.tag = tag; it.exp = e;
    sbq.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic pulse_ref();
    ref_in = 1'b1; wait_cyc(4); ref_in = 1'b0; wait_cyc(4);
  endtask

  task automatic pulse_fg();
    fg_in = 1'b1; wait_cyc(4); fg_in = 1'b0; wait_cyc(4);
  endtask

  task automatic do_tick(input bit with_ref, input bit with_fg);
    tick_in = 1'b1; wait_cyc(4); tick_in = 1'b0; wait_cyc(4);
    if (with_ref) pulse_ref();
    if (with_fg) pulse_fg();
  endtask

  task automatic set_stop(input logic v);
    stop_req = v; wait_cyc(6);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wait_cyc(5);
    expect_out("R1 held in reset", 3'b101);
    rst_n = 1'b1; wait_cyc(10);
    expect_out("R1 before first tick", 3'b101);
    do_tick(1, 1);
    expect_out("R1 released after tick", 3'b000);

    for (int i = 0; i < 10; i++) do_tick(1, 1);
    expect_out("R4 steady reference", 3'b000);

    do_tick(0, 1);
    expect_out("R3 one tick lost", 3'b000);
    do_tick(0, 1);
    expect_out("R3 two ticks lost", 3'b010);
    pulse_ref();
    expect_out("R4 ref edge clears", 3'b000);

    for (int i = 0; i < 30; i++) do_tick(1, 0);
    expect_out("R5 thirty quiet ticks", 3'b000);
    pulse_fg();
    for (int i = 0; i < 30; i++) do_tick(1, 0);
    expect_out("R6 fg restarts count", 3'b000);
    do_tick(1, 0);
    expect_out("R5 stall latched", 3'b001);

    do_tick(1, 1); do_tick(1, 1);
    expect_out("R7 latch holds with fg", 3'b001);
    do_tick(0, 1); do_tick(0, 1);
    expect_out("R3 lost while latched", 3'b011);

    set_stop(1'b1);
    expect_out("R9 stop clears flag", 3'b001);
    do_tick(0, 0);
    expect_out("R2 stop disables", 3'b001);
    set_stop(1'b0);
    expect_out("R7 short stop keeps latch", 3'b001);

    set_stop(1'b1);
    for (int i = 0; i < 3; i++) do_tick(0, 0);
    expect_out("R2 still stopped", 3'b001);
    set_stop(1'b0);
    expect_out("R7 long stop clears latch", 3'b000);

    therm_flt = 1'b1; wait_cyc(2);
    expect_out("R8 thermal disables", 3'b001);
    therm_flt = 1'b0; wait_cyc(2);
    expect_out("R8 thermal recovers", 3'b000);
    uv_flt = 1'b1; wait_cyc(2);
    expect_out("R8 undervoltage disables", 3'b001);
    uv_flt = 1'b0; wait_cyc(2);
    expect_out("R8 undervoltage recovers", 3'b000);

    for (int i = 0; i < 31; i++) do_tick(1, 0);
    expect_out("R5 second stall", 3'b001);
    rst_n = 1'b0; wait_cyc(3);
    expect_out("R10 reset asserted", 3'b101);
    rst_n = 1'b1; wait_cyc(3);
    do_tick(1, 1);
    expect_out("R10 latch cleared by power cycle", 3'b000);

    wait_cyc(3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule